// File: doc/BRIEF.md
# Frame-Aligned Video Parameter Register Bank

This block holds the run-time settings of a colour-conversion video stage. Software writes a set of shadow registers through a simple strobed write port and reads them back through a registered read port. The conversion datapath never sees the shadow registers. It sees an active copy, and that copy changes only at a frame boundary, and only if software has set the commit flag in the control word. Software can clear the commit flag, rewrite any number of parameters, and set the flag again. The whole new set then takes effect together at the next end of frame, so no frame is processed with half old and half new settings.

The control word also holds a run enable, a pass-through select and a pattern select. These reach the datapath as soon as they are written. It also holds two resets. The immediate reset takes effect at once and holds the datapath in reset until software clears it. The frame-aligned reset waits for the current frame to end, or fires at once if the video path reports that no frame is in progress. It then clears itself.

Top module: `vidcfg_regbank`

## Requirements
- R1: After reset the active set and the shadow set hold the compile-time defaults (1920 columns, 1080 rows, luma limits 235/16, chroma limits 240/16, offsets 16/128/128, coefficients 19595/7471/46802/37028), the control word reads 0, and `core_enable`, `core_bypass`, `core_testpat` and `core_reset` are 0.
- R2: A write to a parameter address updates only the shadow copy. A read of that address returns the shadow value on `rd_data` one cycle after `rd_en`. The active outputs do not change.
- R3: When `frame_end` is high at a clock edge and the commit flag (control bit 1) is 1, every active register takes the shadow value. The new value appears on the outputs right after that edge.
- R4: When `frame_end` is high and the commit flag is 0, the active set keeps its value.
- R5: Control bit 0 (run enable), bit 4 (pass-through) and bit 5 (pattern) drive `core_enable`, `core_bypass` and `core_testpat` right after the write edge, whatever the state of the frame. Reading the control word returns the stored bits.
- R6: Writing 1 to control bit 31 raises `core_reset` right after the write edge and keeps it high until bit 31 is written back to 0. While the bit is set, the active set is reloaded with its defaults from the next edge, and frame-end commits are blocked.
- R7: Writing 1 to control bit 30 while `frame_idle` is 0 leaves the request pending, and bit 30 reads back as 1. At the next `frame_end` edge the active set reloads its defaults, and a reload wins over a commit at the same edge. `core_reset` pulses for exactly one cycle and bit 30 reads back as 0 again.
- R8: If bit 30 is pending while `frame_idle` is 1, the frame-aligned reset fires at the next edge, with the same one-cycle pulse and the same default reload.
- R9: Byte address 0x10 reads 0x07010000, and writes to that address have no effect on what it reads.
- R10: Each parameter field stores only its own width: 16-bit limits, 17-bit offsets and 18-bit coefficients. Higher bits read back as 0. An unmapped address reads 0.
- R11: The frame-size word at 0x20 holds the column count in bits 12:0 and the row count in bits 28:16. The parameter words sit at 0x100 + 4*k: luma max, luma min, Cb max, Cb min, Cr max, Cr min, luma offset, Cb offset, Cr offset, then coefficients A to D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; data is valid on the following cycle |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Registered read data (shadow view) |
| frame_end | input | 1 | One-cycle pulse on the last transfer of a frame |
| frame_idle | input | 1 | High while no frame is in progress |
| core_enable | output | 1 | Run enable for the datapath |
| core_bypass | output | 1 | Pass-through select |
| core_testpat | output | 1 | Pattern-generator select |
| core_reset | output | 1 | Datapath reset (immediate level or frame-aligned pulse) |
| act_cols | output | DIM_W | Active column count |
| act_rows | output | DIM_W | Active row count |
| act_lim | output | 6 x LIM_W | Active clip limits: Y max, Y min, Cb max, Cb min, Cr max, Cr min |
| act_off | output | 3 x OFF_W | Active offsets: Y, Cb, Cr |
| act_coef | output | 4 x COEF_W | Active matrix coefficients A to D |

## Verification
The hardest case to reach is a frame-aligned reset that is pending at the same end-of-frame edge as a commit of freshly written shadow values. The stimulus first commits values that differ from the defaults. It then writes a new shadow value, sets both the commit flag and the reset request with a single control write, and raises `frame_end`. The outputs must show the defaults, not the shadow, for exactly the cycle of the reset pulse. The commit must then come through on the following frame. A second hard case is the idle-path shortcut. Here `frame_idle` is held high before the request is written, and the bench samples the cycle right after the write and the cycle after that, to check that the pulse comes one edge after the write.

// File: rtl/vidcfg_pkg.sv
`timescale 1ns/1ps
package vidcfg_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned NLIM   = 6;
  localparam int unsigned NOFF   = 3;
  localparam int unsigned NCOEF  = 4;
  localparam int unsigned NPAR   = 1 + NLIM + NOFF + NCOEF;

  // entry indices in the parameter file
  localparam int unsigned IX_SIZE  = 0;
  localparam int unsigned IX_LIM0  = 1;
  localparam int unsigned IX_OFF0  = IX_LIM0 + NLIM;
  localparam int unsigned IX_COEF0 = IX_OFF0 + NOFF;

  // byte addresses
  localparam int unsigned ADDR_CTRL = 32'h000;
  localparam int unsigned ADDR_VER  = 32'h010;
  localparam int unsigned ADDR_SIZE = 32'h020;
  localparam int unsigned ADDR_PAR0 = 32'h100;

  localparam logic [REG_W-1:0] VERSION_WORD = 32'h0701_0000;

  // control word bit positions
  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_COMMIT = 1;
  localparam int unsigned CB_PASS = 4;
  localparam int unsigned CB_PATT = 5;
  localparam int unsigned CB_FRST = 30;
  localparam int unsigned CB_IRST = 31;
  localparam logic [REG_W-1:0] CTRL_MASK = 32'hC000_0033;

  localparam int unsigned ROWS_LSB = 16;

  typedef logic [REG_W-1:0] word_t;
  typedef word_t [NPAR-1:0] parset_t;

  function automatic word_t ones(input int unsigned w);
    word_t r;
    r = '0;
    for (int i = 0; i < int'(REG_W); i++)
      if (i < int'(w)) r[i] = 1'b1;
    return r;
  endfunction

  function automatic word_t field_mask(input int unsigned idx, input int unsigned dim_w,
                                       input int unsigned lim_w, input int unsigned off_w,
                                       input int unsigned coef_w);
    word_t m;
    if (idx == IX_SIZE)       m = ones(dim_w) | (ones(dim_w) << ROWS_LSB);
    else if (idx < IX_OFF0)   m = ones(lim_w);
    else if (idx < IX_COEF0)  m = ones(off_w);
    else                      m = ones(coef_w);
    return m;
  endfunction

  function automatic int unsigned par_addr(input int unsigned idx);
    return (idx == IX_SIZE) ? ADDR_SIZE : ADDR_PAR0 + 4 * (idx - 1);
  endfunction

endpackage

// File: rtl/vidcfg_ctrl.sv
`timescale 1ns/1ps
module vidcfg_ctrl
  import vidcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  logic              frame_end,
  input  logic              frame_idle,
  output word_t             ctrl_q,
  output logic              frst_fire,
  output logic              core_reset
);

  logic  ctrl_hit;
  word_t ctrl_d;
  logic  fire_q;

  assign ctrl_hit  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  // pending frame reset fires at end of frame or at once when idle
  assign frst_fire = ctrl_q[CB_FRST] && (frame_end || frame_idle);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_hit) ctrl_d = wr_data & CTRL_MASK;
    ctrl_d[CB_FRST] = (ctrl_q[CB_FRST] && !frst_fire) || (ctrl_hit && wr_data[CB_FRST]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fire_q <= 1'b0;
    end else begin
      if (ctrl_hit || frst_fire) ctrl_q <= ctrl_d;
      fire_q <= frst_fire;
    end
  end

  assign core_reset = ctrl_q[CB_IRST] || fire_q;

endmodule

// File: rtl/vidcfg_shadow.sv
`timescale 1ns/1ps
module vidcfg_shadow
  import vidcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DIM_W  = 13,
  parameter int unsigned LIM_W  = 16,
  parameter int unsigned OFF_W  = 17,
  parameter int unsigned COEF_W = 18,
  parameter parset_t     DEF_SET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  output parset_t           sh_q
);

  parset_t sh_d;

  for (genvar g = 0; g < int'(NPAR); g++) begin : g_ent
    localparam word_t MSK = field_mask(g, DIM_W, LIM_W, OFF_W, COEF_W);
    logic hit;
    assign hit     = wr_en && (wr_addr == ADDR_W'(par_addr(g)));
    assign sh_d[g] = hit ? (wr_data & MSK) : sh_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= DEF_SET;
    else if (wr_en) sh_q <= sh_d;
  end

endmodule

// File: rtl/vidcfg_active.sv
`timescale 1ns/1ps
module vidcfg_active
  import vidcfg_pkg::*;
#(
  parameter parset_t DEF_SET = '0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  parset_t sh_q,
  input  logic    frame_end,
  input  logic    commit_on,
  input  logic    load_def,
  output parset_t act_q
);

  logic    commit;
  logic    act_en;
  parset_t act_d;

  assign commit = frame_end && commit_on;
  assign act_en = load_def || commit;

  // reload of defaults outranks a commit
  always_comb begin
    if (load_def)    act_d = DEF_SET;
    else if (commit) act_d = sh_q;
    else             act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= DEF_SET;
    else if (act_en) act_q <= act_d;
  end

endmodule

// File: rtl/vidcfg_readmux.sv
`timescale 1ns/1ps
module vidcfg_readmux
  import vidcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  word_t             ctrl_q,
  input  parset_t           sh_q,
  output word_t             rd_data
);

  word_t rd_d;

  always_comb begin
    rd_d = '0;
    if (rd_addr == ADDR_W'(ADDR_CTRL))     rd_d = ctrl_q;
    else if (rd_addr == ADDR_W'(ADDR_VER)) rd_d = VERSION_WORD;
    for (int i = 0; i < int'(NPAR); i++)
      if (rd_addr == ADDR_W'(par_addr(i))) rd_d = sh_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_d;
  end

endmodule

// File: rtl/vidcfg_regbank.sv
`timescale 1ns/1ps
module vidcfg_regbank
  import vidcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DIM_W  = 13,
  parameter int unsigned LIM_W  = 16,
  parameter int unsigned OFF_W  = 17,
  parameter int unsigned COEF_W = 18,
  parameter logic [DIM_W-1:0] DEF_COLS = DIM_W'(1920),
  parameter logic [DIM_W-1:0] DEF_ROWS = DIM_W'(1080),
  parameter logic [NLIM-1:0][LIM_W-1:0] DEF_LIM =
    {LIM_W'(16), LIM_W'(240), LIM_W'(16), LIM_W'(240), LIM_W'(16), LIM_W'(235)},
  parameter logic [NOFF-1:0][OFF_W-1:0] DEF_OFF =
    {OFF_W'(128), OFF_W'(128), OFF_W'(16)},
  parameter logic [NCOEF-1:0][COEF_W-1:0] DEF_COEF =
    {COEF_W'(37028), COEF_W'(46802), COEF_W'(7471), COEF_W'(19595)}
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [31:0]                    wr_data,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [31:0]                    rd_data,
  input  logic                           frame_end,
  input  logic                           frame_idle,
  output logic                           core_enable,
  output logic                           core_bypass,
  output logic                           core_testpat,
  output logic                           core_reset,
  output logic [DIM_W-1:0]               act_cols,
  output logic [DIM_W-1:0]               act_rows,
  output logic [NLIM-1:0][LIM_W-1:0]     act_lim,
  output logic [NOFF-1:0][OFF_W-1:0]     act_off,
  output logic [NCOEF-1:0][COEF_W-1:0]   act_coef
);

  function automatic parset_t def_set();
    parset_t s;
    s = '0;
    s[IX_SIZE] = word_t'(DEF_COLS) | (word_t'(DEF_ROWS) << ROWS_LSB);
    for (int k = 0; k < int'(NLIM); k++)  s[IX_LIM0 + k]  = word_t'(DEF_LIM[k]);
    for (int k = 0; k < int'(NOFF); k++)  s[IX_OFF0 + k]  = word_t'(DEF_OFF[k]);
    for (int k = 0; k < int'(NCOEF); k++) s[IX_COEF0 + k] = word_t'(DEF_COEF[k]);
    return s;
  endfunction

  localparam parset_t DEF_SET = def_set();

  word_t   ctrl_q;
  logic    frst_fire;
  logic    load_def;
  parset_t sh_q;
  parset_t act_q;

  vidcfg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_end  (frame_end),
    .frame_idle (frame_idle),
    .ctrl_q     (ctrl_q),
    .frst_fire  (frst_fire),
    .core_reset (core_reset)
  );

  vidcfg_shadow #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .LIM_W(LIM_W), .OFF_W(OFF_W),
    .COEF_W(COEF_W), .DEF_SET(DEF_SET)
  ) shadow_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sh_q    (sh_q)
  );

  assign load_def = ctrl_q[CB_IRST] || frst_fire;

  vidcfg_active #(.DEF_SET(DEF_SET)) active_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sh_q      (sh_q),
    .frame_end (frame_end),
    .commit_on (ctrl_q[CB_COMMIT]),
    .load_def  (load_def),
    .act_q     (act_q)
  );

  vidcfg_readmux #(.ADDR_W(ADDR_W)) readmux_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .ctrl_q  (ctrl_q),
    .sh_q    (sh_q),
    .rd_data (rd_data)
  );

  assign core_enable  = ctrl_q[CB_RUN];
  assign core_bypass  = ctrl_q[CB_PASS];
  assign core_testpat = ctrl_q[CB_PATT];

  assign act_cols = act_q[IX_SIZE][DIM_W-1:0];
  assign act_rows = act_q[IX_SIZE][ROWS_LSB +: DIM_W];

  for (genvar k = 0; k < int'(NLIM); k++) begin : g_lim
    assign act_lim[k] = act_q[IX_LIM0 + k][LIM_W-1:0];
  end
  for (genvar k = 0; k < int'(NOFF); k++) begin : g_off
    assign act_off[k] = act_q[IX_OFF0 + k][OFF_W-1:0];
  end
  for (genvar k = 0; k < int'(NCOEF); k++) begin : g_coef
    assign act_coef[k] = act_q[IX_COEF0 + k][COEF_W-1:0];
  end

endmodule

// File: rtl/vidcfg_regbank_chk.sv
`timescale 1ns/1ps
module vidcfg_regbank_chk
  import vidcfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter parset_t     DEF_SET = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wd_run,
  input logic              wd_frst,
  input logic              frame_end,
  input word_t             ctrl_q,
  input logic              frst_fire,
  input logic              core_reset,
  input logic              core_enable,
  input parset_t           sh_q,
  input parset_t           act_q
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == '0);

  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sh_q));

  // R3
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ctrl_q[CB_COMMIT] && !ctrl_q[CB_IRST] && !frst_fire)
      |=> (act_q == $past(sh_q)));

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(frame_end && ctrl_q[CB_COMMIT]) && !ctrl_q[CB_IRST] && !frst_fire)
      |=> $stable(act_q));

  // R5
  run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (core_enable == $past(wd_run)));

  // R6
  irst_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_IRST] |-> core_reset);

  // R6
  irst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_IRST] |=> (act_q == DEF_SET));

  // R7
  frst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frst_fire && !(ctrl_wr && wd_frst))
      |=> (!ctrl_q[CB_FRST] && core_reset && act_q == DEF_SET));

endmodule

bind vidcfg_regbank vidcfg_regbank_chk #(.ADDR_W(ADDR_W), .DEF_SET(DEF_SET)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wd_run      (wr_data[0]),
  .wd_frst     (wr_data[30]),
  .frame_end   (frame_end),
  .ctrl_q      (ctrl_q),
  .frst_fire   (frst_fire),
  .core_reset  (core_reset),
  .core_enable (core_enable),
  .sh_q        (sh_q),
  .act_q       (act_q)
);

// File: tb/vidcfg_regbank_tb_top.sv
`timescale 1ns/1ps
module vidcfg_regbank_tb_top;

  localparam int ADDR_W = 12;
  localparam int DIM_W  = 13;
  localparam int LIM_W  = 16;
  localparam int OFF_W  = 17;
  localparam int COEF_W = 18;

  localparam logic [31:0] A_CTRL = 32'h000, A_VER = 32'h010, A_SIZE = 32'h020;
  localparam logic [31:0] A_YMAX = 32'h100, A_YMIN = 32'h104, A_CD = 32'h130;

  logic clk, rst_n;
  logic wr_en, rd_en, frame_end, frame_idle;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic core_enable, core_bypass, core_testpat, core_reset;
  logic [DIM_W-1:0] act_cols, act_rows;
  logic [5:0][LIM_W-1:0] act_lim;
  logic [2:0][OFF_W-1:0] act_off;
  logic [3:0][COEF_W-1:0] act_coef;

  int checks = 0;
  int errors = 0;

  vidcfg_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .frame_end(frame_end),
    .frame_idle(frame_idle), .core_enable(core_enable), .core_bypass(core_bypass),
    .core_testpat(core_testpat), .core_reset(core_reset), .act_cols(act_cols),
    .act_rows(act_rows), .act_lim(act_lim), .act_off(act_off), .act_coef(act_coef)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[ADDR_W-1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a[ADDR_W-1:0];
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 enable", 32'(core_enable), 0);
    chk("R1 bypass", 32'(core_bypass), 0);
    chk("R1 reset out", 32'(core_reset), 0);
    chk("R1 cols", 32'(act_cols), 1920);
    chk("R1 rows", 32'(act_rows), 1080);
    chk("R1 ymax", 32'(act_lim[0]), 235);
    chk("R1 cbmax", 32'(act_lim[2]), 240);
    chk("R1 croff", 32'(act_off[2]), 128);
    chk("R1 coefA", 32'(act_coef[0]), 19595);
    rd(A_CTRL, d); chk("R1 ctrl read", d, 0);
    rd(A_YMAX, d); chk("R1 ymax read", d, 235);
    rd(A_SIZE, d); chk("R1 R11 size read", d, 32'h0438_0780);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    wr(A_YMAX, 32'hABCD_2345);
    rd(A_YMAX, d); chk("R2 R10 ymax shadow", d, 32'h0000_2345);
    chk("R2 ymax active held", 32'(act_lim[0]), 235);
    wr(A_CD, 32'hFFFF_FFFF);
    rd(A_CD, d); chk("R10 coefD mask", d, 32'h0003_FFFF);
    wr(A_SIZE, 32'hE1E0_0280);
    rd(A_SIZE, d); chk("R11 size fields", d, 32'h01E0_0280);
    chk("R2 cols active held", 32'(act_cols), 1920);
    rd(32'h044, d); chk("R10 unmapped", d, 0);
    rd(32'h134, d); chk("R10 past last", d, 0);
  endtask

  task automatic t_commit();
    wr(A_CTRL, 32'h1);
    chk("R5 enable immediate", 32'(core_enable), 1);
    frame_pulse();
    chk("R4 no commit flag", 32'(act_lim[0]), 235);
    wr(A_CTRL, 32'h3);
    chk("R3 before frame end", 32'(act_lim[0]), 235);
    frame_pulse();
    chk("R3 ymax committed", 32'(act_lim[0]), 32'h2345);
    chk("R3 coefD committed", 32'(act_coef[3]), 32'h3FFFF);
    chk("R11 cols committed", 32'(act_cols), 640);
    chk("R11 rows committed", 32'(act_rows), 480);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    wr(A_CTRL, 32'h33);
    chk("R5 bypass", 32'(core_bypass), 1);
    chk("R5 pattern", 32'(core_testpat), 1);
    rd(A_CTRL, d); chk("R5 ctrl read", d, 32'h33);
    wr(A_CTRL, 32'h3);
    chk("R5 bypass off", 32'(core_bypass), 0);
  endtask

  task automatic t_version();
    logic [31:0] d;
    rd(A_VER, d); chk("R9 version", d, 32'h0701_0000);
    wr(A_VER, 32'h0);
    rd(A_VER, d); chk("R9 version after write", d, 32'h0701_0000);
  endtask

  task automatic t_frst_busy();
    logic [31:0] d;
    wr(A_YMIN, 32'h55);
    wr(A_CTRL, 32'h4000_0003);
    chk("R7 no reset yet", 32'(core_reset), 0);
    rd(A_CTRL, d); chk("R7 pending reads 1", d, 32'h4000_0003);
    frame_pulse();
    chk("R7 pulse", 32'(core_reset), 1);
    chk("R7 ymax default", 32'(act_lim[0]), 235);
    chk("R7 ymin default over commit", 32'(act_lim[1]), 16);
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(core_reset), 0);
    rd(A_CTRL, d); chk("R7 self clear", d, 32'h3);
    frame_pulse();
    chk("R3 recommit ymin", 32'(act_lim[1]), 32'h55);
    chk("R3 recommit ymax", 32'(act_lim[0]), 32'h2345);
  endtask

  task automatic t_frst_idle();
    @(negedge clk);
    frame_idle = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_CTRL[ADDR_W-1:0]; wr_data = 32'h4000_0003;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 no pulse at write", 32'(core_reset), 0);
    chk("R8 active before fire", 32'(act_lim[0]), 32'h2345);
    @(negedge clk);
    chk("R8 pulse when idle", 32'(core_reset), 1);
    chk("R8 default reload", 32'(act_lim[0]), 235);
    @(negedge clk);
    chk("R8 pulse ends", 32'(core_reset), 0);
    frame_idle = 1'b0;
    frame_pulse();
    chk("R3 commit after idle reset", 32'(act_lim[0]), 32'h2345);
  endtask

  task automatic t_irst();
    logic [31:0] d;
    wr(A_CTRL, 32'h8000_0003);
    chk("R6 reset immediate", 32'(core_reset), 1);
    @(negedge clk);
    chk("R6 defaults loaded", 32'(act_lim[0]), 235);
    frame_pulse();
    chk("R6 commit blocked", 32'(act_lim[0]), 235);
    chk("R6 reset held", 32'(core_reset), 1);
    rd(A_CTRL, d); chk("R6 ctrl read", d, 32'h8000_0003);
    wr(A_CTRL, 32'h3);
    chk("R6 reset released", 32'(core_reset), 0);
    frame_pulse();
    chk("R6 commit after release", 32'(act_lim[0]), 32'h2345);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; frame_end = 1'b0; frame_idle = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_commit();
    t_modes();
    t_version();
    t_frst_busy();
    t_frst_idle();
    t_irst();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule